// File: doc/BRIEF.md
# Watermark-Driven Prefetch Input Buffer

This block sits between a bulk memory mover and a pixel-processing array. It stores incoming image samples in a circular buffer. It asks the mover for more data early, so the transfer latency is hidden behind the consumer's reads. When the fill level is at or below half of capacity and no burst is outstanding, it raises a refill request. Each refill covers half the buffer, or only the words still owed if the image is nearly complete. Only one burst may be in flight at a time.

After reset the block issues its first request without waiting for any trigger. It stops requesting once it has asked for the configured number of image words. It tells the downstream control to begin once one whole pixel's worth of samples has been buffered. From then on the consumer may take one sample per clock for as long as the buffer holds data. The buffer depth must be a power of two.

Top module: `prefetch_fifo`

## Requirements
- R1: While reset is asserted, fetch_req, start, overflow and rd_valid are all low.
- R2: After reset, a first request is raised within two cycles, with fetch_len equal to the smaller of DEPTH/2 and image_words.
- R3: fetch_req and fetch_len stay unchanged until fetch_ack is seen high at a clock edge, and fetch_req is low in the cycle after that edge.
- R4: After a request is acknowledged, no new request is raised until fetch_len words have arrived on the write port.
- R5: Once the previous burst has fully arrived, a new request is raised if the buffer holds DEPTH/2 entries or fewer. No request is raised while it holds more.
- R6: The sum of all requested lengths never exceeds image_words. The last request is cut down to the words still owed, and no request follows once the total is reached.
- R7: start goes high one cycle after the buffered count first reaches PIXEL_LEN, and stays high until reset.
- R8: rd_valid is high exactly when the buffer is not empty. rd_data shows the oldest sample. With rd_en high, one sample is removed per clock, in write order.
- R9: A write while the buffer holds DEPTH entries is discarded, and overflow becomes high and stays high until reset.
- R10: rd_en while the buffer is empty has no effect. A later write becomes the sample shown on rd_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| image_words | input | TOTAL_W | Total words to fetch for the image; held steady |
| fetch_req | output | 1 | Refill request to the memory mover |
| fetch_len | output | TOTAL_W | Word count of the pending request |
| fetch_ack | input | 1 | Mover accepts the request |
| wr_valid | input | 1 | Incoming sample strobe |
| wr_data | input | DATA_W | Incoming sample |
| overflow | output | 1 | Sticky: a write was discarded because the buffer was full |
| start | output | 1 | Sticky: one pixel is buffered, so processing may begin |
| rd_en | input | 1 | Consumer takes the shown sample |
| rd_valid | output | 1 | Buffer not empty |
| rd_data | output | DATA_W | Oldest buffered sample |

## Verification
The bench follows an image whose size is not a multiple of half the buffer, so the final burst must be shortened. A design that always requested a half-buffer would over-fetch, and one that compared lengths wrongly would stop early. It holds the acknowledge off for several cycles and leaves a burst partly delivered. This catches a design that drops the request on its own, or one that issues a second request while words are still owed. It checks the start flag on the exact cycle after one pixel is buffered, where an off-by-one would show. It writes into a full buffer and reads from an empty one, where a faulty design would overwrite the oldest sample or move its read pointer and later show the wrong data.

// File: rtl/prefetch_fifo.sv
module prefetch_fifo #(
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 1024,
  parameter int PIXEL_LEN = 224,
  parameter int TOTAL_W   = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TOTAL_W-1:0] image_words,
  output logic               fetch_req,
  output logic [TOTAL_W-1:0] fetch_len,
  input  logic               fetch_ack,
  input  logic               wr_valid,
  input  logic [DATA_W-1:0]  wr_data,
  output logic               overflow,
  output logic               start,
  input  logic               rd_en,
  output logic               rd_valid,
  output logic [DATA_W-1:0]  rd_data
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int HALF = DEPTH / 2;

  logic [DATA_W-1:0]  mem [DEPTH];
  logic [AW-1:0]      wp, rp;
  logic [CW-1:0]      count;
  logic [TOTAL_W-1:0] pend, issued, remaining, next_len;
  logic               full, push, pop, want;

  assign full      = count == CW'(DEPTH);
  assign push      = wr_valid && !full;
  assign pop       = rd_en && count != '0;
  assign rd_valid  = count != '0;
  assign rd_data   = mem[rp];
  assign remaining = image_words - issued;
  assign next_len  = (remaining > TOTAL_W'(HALF)) ? TOTAL_W'(HALF) : remaining;
  assign want      = !fetch_req && pend == '0 && issued < image_words
                     && count <= CW'(HALF);

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      count    <= '0;
      overflow <= 1'b0;
      start    <= 1'b0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      count    <= count + CW'(push) - CW'(pop);
      overflow <= overflow || (wr_valid && full);
      start    <= start || (count >= CW'(PIXEL_LEN));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_req <= 1'b0;
      fetch_len <= '0;
      pend      <= '0;
      issued    <= '0;
    end else if (fetch_req && fetch_ack) begin
      fetch_req <= 1'b0;
      pend      <= fetch_len;
      issued    <= issued + fetch_len;
    end else begin
      if (want) begin
        fetch_req <= 1'b1;
        fetch_len <= next_len;
      end
      if (wr_valid && pend != '0) pend <= pend - 1'b1;
    end
  end
endmodule

// File: rtl/prefetch_fifo_chk.sv
module prefetch_fifo_chk #(
  parameter int DEPTH   = 1024,
  parameter int TOTAL_W = 24,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fetch_req,
  input logic               fetch_ack,
  input logic [TOTAL_W-1:0] fetch_len,
  input logic [TOTAL_W-1:0] image_words,
  input logic [TOTAL_W-1:0] pend,
  input logic [TOTAL_W-1:0] issued,
  input logic [CW-1:0]      count,
  input logic               start,
  input logic               overflow,
  input logic               rd_valid
);
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && !fetch_ack |=> fetch_req && $stable(fetch_len));
  p_req_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && fetch_ack |=> !fetch_req);
  p_no_req_inflight_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_req) |-> $past(pend) == '0);
  p_total_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    issued <= image_words);
  p_start_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> start);
  p_empty_invalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) == !rd_valid);
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
endmodule

bind prefetch_fifo prefetch_fifo_chk #(.DEPTH(DEPTH), .TOTAL_W(TOTAL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_ack(fetch_ack),
  .fetch_len(fetch_len), .image_words(image_words), .pend(pend),
  .issued(issued), .count(count), .start(start), .overflow(overflow),
  .rd_valid(rd_valid)
);

// File: tb/prefetch_fifo_test.sv
module prefetch_fifo_test;
  localparam int DW = 16, DEPTH = 8, PLEN = 3, TW = 8;

  logic clk = 0, rst_n = 0;
  logic [TW-1:0] image_words = 8'd10;
  logic fetch_req, fetch_ack = 0, wr_valid = 0, rd_en = 0;
  logic [TW-1:0] fetch_len;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic overflow, start, rd_valid;
  int vectors = 0, errors = 0, cycles = 0;

  always #2 clk = ~clk;

  prefetch_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .PIXEL_LEN(PLEN), .TOTAL_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .image_words(image_words),
    .fetch_req(fetch_req), .fetch_len(fetch_len), .fetch_ack(fetch_ack),
    .wr_valid(wr_valid), .wr_data(wr_data), .overflow(overflow),
    .start(start), .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic wait_req(input string req, input int lim);
    int n = 0;
    while (!fetch_req && n < lim) begin step(); n++; end
    chk(req, fetch_req, 1);
  endtask

  task automatic ack();
    fetch_ack = 1; step(); fetch_ack = 0;
    chk("R3 drop after ack", fetch_req, 0);
  endtask

  task automatic put(input logic [DW-1:0] d);
    wr_valid = 1; wr_data = d; step(); wr_valid = 0;
  endtask

  task automatic take(input string req, input logic [DW-1:0] exp);
    chk({req, " valid"}, rd_valid, 1);
    chk({req, " data"}, rd_data, exp);
    rd_en = 1; step(); rd_en = 0;
  endtask

  task automatic t_reset();
    step(); step();
    chk("R1 req", fetch_req, 0); chk("R1 start", start, 0);
    chk("R1 overflow", overflow, 0); chk("R1 valid", rd_valid, 0);
    rst_n = 1;
  endtask

  task automatic t_first_burst();
    wait_req("R2 first request", 2);
    chk("R2 len", fetch_len, 4);
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R3 held", fetch_req, 1); chk("R3 len", fetch_len, 4);
    end
    ack();
    for (int i = 0; i < 3; i++) begin step(); chk("R4 idle no req", fetch_req, 0); end
    put(100); put(101);
    chk("R4 partial no req", fetch_req, 0);
    chk("R7 start low at 2", start, 0);
    put(102);
    chk("R7 start low same cycle", start, 0);
    put(103);
    chk("R7 start high", start, 1);
  endtask

  task automatic t_refill_and_full();
    wait_req("R5 refill at half", 2);
    chk("R5 len", fetch_len, 4);
    ack();
    for (int i = 0; i < 4; i++) put(DW'(104 + i));
    step(); step();
    chk("R5 no req above half", fetch_req, 0);
    put(99);
    chk("R9 overflow set", overflow, 1);
    for (int i = 0; i < 4; i++) take("R8 order", DW'(100 + i));
    chk("R9 overflow sticky", overflow, 1);
  endtask

  task automatic t_last_burst();
    wait_req("R6 last request", 2);
    chk("R6 short len", fetch_len, 2);
    ack();
    put(108); put(109);
    for (int i = 0; i < 6; i++) take("R8 drain", DW'(104 + i));
    chk("R8 empty", rd_valid, 0);
    for (int i = 0; i < 4; i++) begin step(); chk("R6 no more req", fetch_req, 0); end
    chk("R7 start stays", start, 1);
  endtask

  task automatic t_empty_read();
    rd_en = 1; step(); step(); rd_en = 0;
    chk("R10 valid low", rd_valid, 0);
    put(200);
    chk("R10 valid after write", rd_valid, 1);
    chk("R10 head data", rd_data, 200);
  endtask

  initial begin
    t_reset();
    t_first_burst();
    t_refill_and_full();
    t_last_burst();
    t_empty_read();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<5000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule